// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-serviced watchdog for a system management controller. A 10-bit down-counter steps once per slow tick pulse (one tick stands for 0.6 s of wall time). Software keeps it from expiring by writing the reload register, which puts the programmed start value back into the counter. A halt bit in the control register freezes counting. After reset the halt bit is set, so software must clear it before the watchdog runs.

Expiry has two stages. When the counter runs out the first time, a sticky first-timeout flag sets, the counter restarts from the start value, and an interrupt output rises if interrupts are enabled. If the counter runs out again before software clears that flag, a sticky second-timeout flag sets and a reset request goes out. A no-reboot gate in the control register holds the reset request low. A second expiry that this gate blocks is recorded in a separate boot flag. Software accesses the registers through a 16-bit write/read port with byte-lane enables. Reads are combinational.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the count and start value are 4, the control register reads 0x0802 (halt=1, no-reboot=1, interrupt enable=0), all flags are clear, and irq_o and rst_req_o are low.
- R2: While halt is 0, each cycle with tick_en high lowers a non-zero count by one. A cycle without tick_en leaves the count unchanged.
- R3: Any write to offset 0 with at least one lane enabled loads the count with the start value, and this takes priority over a tick in the same cycle. A read of offset 0 returns the count in bits [9:0] with zeros above.
- R4: Bit 11 of the control register (offset 4) is the halt bit. While it is 1 the count does not change on ticks.
- R5: The start value sits in bits [9:0] of offset 1. A write whose merged value is 0 to 3 is dropped and the old value stays. Bits [15:10] read as zero and no write changes them.
- R6: A tick that finds the count at 0 while running is an expiry. The first expiry sets bit 3 of offset 2 and reloads the count. irq_o equals that flag ANDed with control bit 0.
- R7: An expiry while the first flag is set sets bit 1 of offset 3. rst_req_o equals that flag ANDed with NOT control bit 1.
- R8: rst_req_o stays low while control bit 1 (no-reboot) is 1. A second expiry that occurs while the gate is closed also sets the boot flag, bit 2 of offset 3.
- R9: Flag bits are cleared by writing 1. Writing 0 leaves them unchanged. A flag that sets in the same cycle as its clear stays set.
- R10: bus_be[0] enables bits [7:0] and bus_be[1] enables bits [15:8]. A write changes only bits in enabled lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | One-cycle pulse per watchdog tick |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register offset |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | First-timeout interrupt |
| rst_req_o | output | 1 | Second-timeout reset request |

## Verification
The bench targets four corner cases:
- A reload write that lands on the same cycle as an expiring tick. A design that gives the tick priority would raise a spurious first timeout.
- A start-value write of 0 to 3, including one that becomes small only after a single lane merges with the old value. A wrong design would accept it and expire almost at once.
- A second expiry with the no-reboot gate closed. A wrong design would either pulse the reset request or lose the record in the boot flag.
- Write-one-to-clear of one flag next to another. Clearing the wrong bit, or clearing a flag that sets in the same cycle, shows up as a status read that differs from the bench model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // register offsets
  localparam int OFF_COUNT = 0;
  localparam int OFF_INIT  = 1;
  localparam int OFF_STAT1 = 2;
  localparam int OFF_STAT2 = 3;
  localparam int OFF_CTRL  = 4;

  // bit positions software depends on
  localparam int HALT_BIT     = 11;
  localparam int IRQEN_BIT    = 0;
  localparam int NOREBOOT_BIT = 1;
  localparam int FIRST_BIT    = 3;
  localparam int SECOND_BIT   = 1;
  localparam int BOOT_BIT     = 2;

  typedef struct packed {
    logic halt;
    logic noreboot;
    logic irq_en;
  } ctrl_t;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } flag_vec_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int INIT_RST = 4,
  parameter int INIT_MIN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_be,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [CNT_W-1:0]      count_i,
  input  flag_vec_t             flags_i,
  output logic [CNT_W-1:0]      init_o,
  output ctrl_t                 ctrl_o,
  output logic                  reload_o,
  output flag_vec_t             clr_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] lane_mask;
  logic [CNT_W-1:0]  init_q, init_d, init_merge;
  logic              init_we;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ctrl_we;
  logic              hit_count, hit_init, hit_stat1, hit_stat2, hit_ctrl;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_mask[l*8 +: 8] = {8{bus_be[l]}};
    end
  endgenerate

  assign hit_count = bus_wr && (bus_addr == ADDR_W'(OFF_COUNT));
  assign hit_init  = bus_wr && (bus_addr == ADDR_W'(OFF_INIT));
  assign hit_stat1 = bus_wr && (bus_addr == ADDR_W'(OFF_STAT1));
  assign hit_stat2 = bus_wr && (bus_addr == ADDR_W'(OFF_STAT2));
  assign hit_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));

  // reload strobe: any enabled lane
  assign reload_o = hit_count && (|bus_be);

  // write-one-to-clear strobes, per enabled lane
  always_comb begin
    clr_o.first  = hit_stat1 && lane_mask[FIRST_BIT]  && bus_wdata[FIRST_BIT];
    clr_o.second = hit_stat2 && lane_mask[SECOND_BIT] && bus_wdata[SECOND_BIT];
    clr_o.boot   = hit_stat2 && lane_mask[BOOT_BIT]   && bus_wdata[BOOT_BIT];
  end

  // start value: lane merge, then floor check
  always_comb begin
    init_merge = (init_q & ~lane_mask[CNT_W-1:0]) |
                 (bus_wdata[CNT_W-1:0] & lane_mask[CNT_W-1:0]);
    init_we    = hit_init && (init_merge >= CNT_W'(INIT_MIN));
    init_d     = init_merge;
  end

  // control next state
  always_comb begin
    ctrl_we = hit_ctrl && (|bus_be);
    ctrl_d  = ctrl_q;
    if (lane_mask[HALT_BIT])     ctrl_d.halt     = bus_wdata[HALT_BIT];
    if (lane_mask[NOREBOOT_BIT]) ctrl_d.noreboot = bus_wdata[NOREBOOT_BIT];
    if (lane_mask[IRQEN_BIT])    ctrl_d.irq_en   = bus_wdata[IRQEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= CNT_W'(INIT_RST);
    end else if (init_we) begin
      init_q <= init_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{halt: 1'b1, noreboot: 1'b1, irq_en: 1'b0};
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  // combinational read mux
  always_comb begin
    rdata_o = '0;
    unique case (bus_addr)
      ADDR_W'(OFF_COUNT): rdata_o[CNT_W-1:0] = count_i;
      ADDR_W'(OFF_INIT):  rdata_o[CNT_W-1:0] = init_q;
      ADDR_W'(OFF_STAT1): rdata_o[FIRST_BIT] = flags_i.first;
      ADDR_W'(OFF_STAT2): begin
        rdata_o[SECOND_BIT] = flags_i.second;
        rdata_o[BOOT_BIT]   = flags_i.boot;
      end
      ADDR_W'(OFF_CTRL): begin
        rdata_o[HALT_BIT]     = ctrl_q.halt;
        rdata_o[NOREBOOT_BIT] = ctrl_q.noreboot;
        rdata_o[IRQEN_BIT]    = ctrl_q.irq_en;
      end
      default: rdata_o = '0;
    endcase
  end

  assign init_o = init_q;
  assign ctrl_o = ctrl_q;

  // R5: the stored start value never falls below the floor
  p_init_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(INIT_MIN));

  // R10: a write with the upper lane off leaves halt alone
  p_halt_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && !bus_be[HALT_BIT/8]) |=> (ctrl_q.halt == $past(ctrl_q.halt)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             cnt_en, step, at_zero;

  assign step     = tick_i && !halt_i;
  assign at_zero  = (count_q == '0);
  assign expire_o = step && at_zero && !reload_i;
  assign cnt_en   = reload_i || step;

  always_comb begin
    if (reload_i)     count_d = init_i;
    else if (at_zero) count_d = init_i;
    else              count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= CNT_W'(INIT_RST);
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  // R3: reload restores the start value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (count_q == $past(init_i)));

  // R4: halted counter holds
  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !reload_i) |=> $stable(count_q));

  // R2: one step per tick
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !halt_i && !reload_i && count_q != '0) |=>
      (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      expire_i,
  input  logic      noreboot_i,
  input  flag_vec_t clr_i,
  output flag_vec_t flags_o
);
  flag_vec_t flags_q, flags_d;
  logic      first_set, second_set;

  assign first_set  = expire_i && !flags_q.first;
  assign second_set = expire_i &&  flags_q.first;

  // set beats clear
  always_comb begin
    flags_d.first  = first_set  || (flags_q.first  && !clr_i.first);
    flags_d.second = second_set || (flags_q.second && !clr_i.second);
    flags_d.boot   = (second_set && noreboot_i) || (flags_q.boot && !clr_i.boot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // R7: a second timeout needs a standing first timeout
  p_second_after_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.second) |-> $past(flags_q.first));

  // R8: boot record only from a gated second timeout
  p_boot_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.boot) |-> $past(noreboot_i && expire_i));

  // R9: a clear with no expiry leaves the first flag low
  p_clear_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i.first && !expire_i) |=> !flags_q.first);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int INIT_RST = 4,
  parameter int INIT_MIN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                rst_req_o
);
  logic [CNT_W-1:0] count, init_val;
  ctrl_t            ctrl;
  flag_vec_t        flags, clr;
  logic             reload, expire;

  wdt_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .INIT_RST(INIT_RST), .INIT_MIN(INIT_MIN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .count_i(count),
    .flags_i(flags), .init_o(init_val), .ctrl_o(ctrl),
    .reload_o(reload), .clr_o(clr), .rdata_o(bus_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .halt_i(ctrl.halt),
    .reload_i(reload), .init_i(init_val), .count_o(count), .expire_o(expire)
  );

  wdt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .expire_i(expire),
    .noreboot_i(ctrl.noreboot), .clr_i(clr), .flags_o(flags)
  );

  assign irq_o     = flags.first  && ctrl.irq_en;
  assign rst_req_o = flags.second && !ctrl.noreboot;

  // R6: the first flag rises only on an expiry
  p_first_on_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.first) |-> $past(expire));
endmodule

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [9:0] m_count, m_init;
  logic       m_halt, m_nr, m_irqen, m_f1, m_f2, m_boot;

  always #4 clk = ~clk;

  wdt_two_stage uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [15:0] model_read(input logic [2:0] a);
    logic [15:0] r;
    r = '0;
    case (a)
      3'd0: r[9:0] = m_count;
      3'd1: r[9:0] = m_init;
      3'd2: r[3]   = m_f1;
      3'd3: begin r[1] = m_f2; r[2] = m_boot; end
      3'd4: begin r[11] = m_halt; r[1] = m_nr; r[0] = m_irqen; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_count = 10'd4; m_init = 10'd4;
    m_halt = 1'b1; m_nr = 1'b1; m_irqen = 1'b0;
    m_f1 = 1'b0; m_f2 = 1'b0; m_boot = 1'b0;
  endtask

  task automatic model_step(input logic wr, input logic [2:0] a, input logic [1:0] be,
                            input logic [15:0] d, input logic tk);
    logic [15:0] mk;
    logic [9:0]  cand, old_init;
    logic        rl, ex, fs, ss, old_nr;
    mk = {{8{be[1]}}, {8{be[0]}}};
    old_init = m_init;
    old_nr = m_nr;
    rl = wr && (a == 3'd0) && (be != 2'b00);
    ex = tk && !m_halt && (m_count == 10'd0) && !rl;
    fs = ex && !m_f1;
    ss = ex && m_f1;
    if (rl) m_count = old_init;
    else if (tk && !m_halt) m_count = (m_count == 10'd0) ? old_init : m_count - 10'd1;
    m_f1   = fs || (m_f1 && !(wr && a == 3'd2 && mk[3] && d[3]));
    m_f2   = ss || (m_f2 && !(wr && a == 3'd3 && mk[1] && d[1]));
    m_boot = (ss && old_nr) || (m_boot && !(wr && a == 3'd3 && mk[2] && d[2]));
    if (wr && a == 3'd1) begin
      cand = (m_init & ~mk[9:0]) | (d[9:0] & mk[9:0]);
      if (cand >= 10'd4) m_init = cand;
    end
    if (wr && a == 3'd4) begin
      if (be[1]) m_halt = d[11];
      if (be[0]) begin m_nr = d[1]; m_irqen = d[0]; end
    end
  endtask

  // one bus cycle, compared against the model every time
  task automatic op(input logic wr, input logic [2:0] a, input logic [1:0] be,
                    input logic [15:0] d, input logic tk);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d; tick_en = tk;
    #1;
    check(tag_of(a), bus_rdata, model_read(a));
    check("R6 irq", {15'd0, irq_o}, {15'd0, m_f1 && m_irqen});
    check("R8 rst_req", {15'd0, rst_req_o}, {15'd0, m_f2 && !m_nr});
    @(posedge clk);
    model_step(wr, a, be, d, tk);
  endtask

  // idle cycle with explicit expected values
  task automatic probe(input logic [2:0] a, input logic [15:0] exp_rd,
                       input logic exp_irq, input logic exp_rst, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; bus_be = 2'b00; bus_wdata = '0; tick_en = 1'b0;
    #1;
    check(tag, bus_rdata, exp_rd);
    check(tag, {15'd0, irq_o}, {15'd0, exp_irq});
    check(tag, {15'd0, rst_req_o}, {15'd0, exp_rst});
    @(posedge clk);
    model_step(1'b0, a, 2'b00, 16'h0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 3'd0, 2'b00, 16'h0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0]  ra;
    logic [1:0]  rb;
    logic [15:0] rd;
    logic        rt;
    int          sel;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe(3'd0, 16'h0004, 1'b0, 1'b0, "R1 count");
    probe(3'd1, 16'h0004, 1'b0, 1'b0, "R1 init");
    probe(3'd2, 16'h0000, 1'b0, 1'b0, "R1 stat1");
    probe(3'd3, 16'h0000, 1'b0, 1'b0, "R1 stat2");
    probe(3'd4, 16'h0802, 1'b0, 1'b0, "R1 ctrl");

    // R5 floor and upper bits, R10 lanes
    op(1'b1, 3'd1, 2'b11, 16'h0003, 1'b0);
    probe(3'd1, 16'h0004, 1'b0, 1'b0, "R5 small value dropped");
    op(1'b1, 3'd1, 2'b11, 16'hFC06, 1'b0);
    probe(3'd1, 16'h0006, 1'b0, 1'b0, "R5 upper bits zero");
    op(1'b1, 3'd1, 2'b01, 16'hFC07, 1'b0);
    probe(3'd1, 16'h0007, 1'b0, 1'b0, "R10 low lane only");
    op(1'b1, 3'd1, 2'b10, 16'h0100, 1'b0);
    probe(3'd1, 16'h0107, 1'b0, 1'b0, "R10 high lane only");
    op(1'b1, 3'd1, 2'b11, 16'h0004, 1'b0);

    // R4 halted counter ignores ticks
    ticks(3);
    probe(3'd0, 16'h0004, 1'b0, 1'b0, "R4 halted count holds");

    // R10 control lane: halt untouched by low-lane write
    op(1'b1, 3'd4, 2'b01, 16'h0003, 1'b0);
    probe(3'd4, 16'h0803, 1'b0, 1'b0, "R10 ctrl low lane");
    op(1'b1, 3'd4, 2'b11, 16'h0003, 1'b0);
    probe(3'd4, 16'h0003, 1'b0, 1'b0, "R4 halt cleared");

    // R2 stepping, R6 first expiry
    op(1'b1, 3'd0, 2'b11, 16'h0000, 1'b0);
    ticks(2);
    probe(3'd0, 16'h0002, 1'b0, 1'b0, "R2 two steps");
    ticks(3);
    probe(3'd2, 16'h0008, 1'b1, 1'b0, "R6 first timeout");
    probe(3'd0, 16'h0004, 1'b1, 1'b0, "R6 reload on expiry");

    // R8 gated second expiry sets boot flag
    ticks(5);
    probe(3'd3, 16'h0006, 1'b1, 1'b0, "R8 gated second timeout");
    // R7 opening the gate raises the request
    op(1'b1, 3'd4, 2'b11, 16'h0001, 1'b0);
    probe(3'd3, 16'h0006, 1'b1, 1'b1, "R7 reset request");

    // R9 write-one-to-clear
    op(1'b1, 3'd3, 2'b11, 16'h0002, 1'b0);
    probe(3'd3, 16'h0004, 1'b1, 1'b0, "R9 clear second only");
    op(1'b1, 3'd3, 2'b11, 16'h0004, 1'b0);
    probe(3'd3, 16'h0000, 1'b1, 1'b0, "R9 clear boot");
    op(1'b1, 3'd2, 2'b11, 16'h0000, 1'b0);
    probe(3'd2, 16'h0008, 1'b1, 1'b0, "R9 zero write keeps flag");
    op(1'b1, 3'd2, 2'b11, 16'h0008, 1'b0);
    probe(3'd2, 16'h0000, 1'b0, 1'b0, "R9 clear first");

    // R3 reload beats expiring tick
    op(1'b1, 3'd0, 2'b11, 16'h0000, 1'b0);
    ticks(4);
    probe(3'd0, 16'h0000, 1'b0, 1'b0, "R2 reached zero");
    op(1'b1, 3'd0, 2'b01, 16'h0000, 1'b1);
    probe(3'd0, 16'h0004, 1'b0, 1'b0, "R3 reload priority");
    probe(3'd2, 16'h0000, 1'b0, 1'b0, "R3 no expiry on reload");

    // R7 ungated second expiry, no boot record
    ticks(10);
    probe(3'd3, 16'h0002, 1'b1, 1'b1, "R7 ungated second timeout");

    // R9 set beats clear: first flag cleared on the expiring tick
    op(1'b1, 3'd2, 2'b11, 16'h0008, 1'b0);
    op(1'b1, 3'd3, 2'b11, 16'h0006, 1'b0);
    ticks(4);
    op(1'b1, 3'd2, 2'b01, 16'h0008, 1'b1);
    probe(3'd2, 16'h0008, 1'b1, 1'b0, "R9 set wins over clear");

    // constrained random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      sel = $urandom % 100;
      rb  = 2'($urandom % 4);
      rt  = ($urandom % 3) == 0;
      rd  = 16'($urandom);
      if (sel < 50) begin
        ra = 3'($urandom % 6);
        op(1'b0, ra, rb, rd, rt);
      end else if (sel < 60) begin
        op(1'b1, 3'd0, rb, rd, rt);
      end else if (sel < 70) begin
        op(1'b1, 3'd1, rb, 16'($urandom % 12) | (rd & 16'hFC00), rt);
      end else if (sel < 78) begin
        rd[11] = ($urandom % 8) == 0;
        op(1'b1, 3'd4, rb, rd, rt);
      end else if (sel < 89) begin
        op(1'b1, 3'd2, rb, rd, rt);
      end else begin
        op(1'b1, 3'd3, rb, rd, rt);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule